// File: doc/BRIEF.md
# MDIO Management Master

This block is a bus master for the two-wire Ethernet PHY management interface. It has a clock line driven by the master and a bidirectional data line. Software uses it through two 32-bit words on a small register port. The command word holds an opcode, a 5-bit PHY address, a 5-bit register address and a 16-bit data field. Setting its launch bit sends one Clause 22 management frame. The configuration word holds a framing-enable bit, the clock divider and a preamble-skip bit.

During a frame the block makes the management clock from the reference clock and shifts the frame out MSB first. On a read it releases the data line for the turnaround and data bits. It samples the PHY's reply on rising management-clock edges and puts the 16 sampled bits back into the command word. If the PHY does not pull the second turnaround bit low, a read-fail flag is set. Software polls the launch bit, which reads back as busy until the frame ends.

Top module: `mdio_master`

## Requirements
- R1: After reset the command word reads 0x00000000. The configuration word reads framing-enable (bit 0) = 1, preamble-skip (bit 12) = 0 and a divider (bits 9:4) equal to the smallest value that gives at most the allowed maximum MDC rate; with the default parameters that is 9, so the word reads 0x00000091. MDC and the data output enable are low.
- R2: The command word sits at byte offset 0x00. Its fields are data in bits 15:0, register address in 20:16, PHY address in 25:21 and opcode in 27:26. Written fields read back unchanged while no frame runs.
- R3: A command write with bit 29 set starts a frame only when three things hold: the block is idle, the opcode is 01 (write) or 10 (read), and configuration bit 0 is set. Bit 29 then reads 1 until the frame ends. A launch write that fails these conditions produces no MDC edge and leaves bit 29 at 0.
- R4: A frame is sent MSB first in this order: 32 one bits of preamble, then 01, the opcode, the PHY address, the register address, two turnaround bits and 16 data bits. When configuration bit 12 is set the preamble is left out, so the frame has 32 MDC cycles instead of 64.
- R5: On a write frame the master drives the turnaround bits as 1 then 0, and then sends the data field.
- R6: On a read frame the output enable is low for the two turnaround bits and the 16 data bits. The data line is sampled on each MDC rising edge, and when the frame ends the 16 data samples are stored in bits 15:0, MSB first.
- R7: Bit 28 of the command word is set at the end of a read frame if the second turnaround bit was sampled as 1. It is cleared when any new frame starts.
- R8: The configuration word at offset 0x04 holds the divider in bits 9:4. One MDC period is 2 × (divider + 1) reference clock cycles.
- R9: MDC is low and the output enable is low whenever no frame runs. During a frame the data output changes only on the reference edge where MDC falls.
- R10: Writes to either word are ignored while a frame runs, including a second launch.
- R11: A command write without bit 29 only stores the fields and starts nothing. A later write of the same word with bit 29 added starts a frame that uses those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of register access |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data output value |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data line as seen at the pad |

## Verification
The bench uses the default parameters: a 50 MHz reference, a 2.5 MHz MDC ceiling that gives a reset divider of 9, and a 4-bit address. One frame runs at the reset divider so that the 20-cycle MDC period is checked. The other frames are set to dividers 0, 1 and 3 to keep them short. This also covers both preamble settings, reads with a good and a bad turnaround, and frames that end at the smallest possible half period of one reference cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int IDX_LAST   = FRAME_BITS - 1;
  localparam int IDX_TA1    = 46;
  localparam int IDX_TA2    = 47;
  localparam int IDX_DATA0  = 48;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regAddr;
    logic [15:0] data;
  } mdioCmd_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic drive;
    logic finish;
    logic capTa;
    logic capData;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  run,
  input  mdioStrobe_t           strobe,
  input  logic [DIV_W-1:0]      divVal,
  input  logic [FRAME_BITS-1:0] frameVec,
  input  logic                  mdioIn,
  output logic                  mdc,
  output logic                  mdioOut,
  output logic                  mdioOe,
  output logic                  riseTick,
  output logic                  fallTick,
  output logic                  taBit,
  output logic [15:0]           rdData
);
  logic [DIV_W-1:0]      divCnt;
  logic [FRAME_BITS-1:0] shiftReg;
  logic                  halfDone;

  assign halfDone = run && (divCnt == divVal);
  assign riseTick = halfDone && !mdc;
  assign fallTick = halfDone && mdc;
  assign mdioOut  = mdioOe & shiftReg[FRAME_BITS-1];

  // half-period counter: MDC toggles every divVal+1 reference cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (!run) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (halfDone) begin
      divCnt <= '0;
      mdc    <= ~mdc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      mdioOe   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= frameVec;
      mdioOe   <= 1'b1;
    end else if (strobe.finish) begin
      mdioOe   <= 1'b0;
    end else if (strobe.advance) begin
      shiftReg <= shiftReg << 1;
      mdioOe   <= strobe.drive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taBit  <= 1'b0;
      rdData <= '0;
    end else begin
      if (strobe.capTa)   taBit  <= mdioIn;
      if (strobe.capData) rdData <= {rdData[14:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int               ADDR_W    = 4,
  parameter int               DIV_W     = 6,
  parameter logic [DIV_W-1:0] DIV_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [31:0]           regWrData,
  output logic [31:0]           regRdData,
  input  logic                  riseTick,
  input  logic                  fallTick,
  input  logic                  taBit,
  input  logic [15:0]           rdData,
  output logic                  run,
  output mdioStrobe_t           strobe,
  output logic [DIV_W-1:0]      divVal,
  output logic [FRAME_BITS-1:0] frameVec,
  output logic                  busy,
  output mdioCmd_t              cmdFields
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [ADDR_W-3:0] CMD_WORD = '0;
  localparam logic [ADDR_W-3:0] CFG_WORD = (ADDR_W-2)'(1);

  mdioCmd_t          cmdQ, newCmd;
  logic              busyQ, failQ, c22Q, preOffQ;
  logic [DIV_W-1:0]  divQ;
  logic [IDX_W-1:0]  bitIdx, nextIdx;
  logic              wrCmd, wrCfg, opValid, startReq, isRead;
  logic [1:0]        taPat;
  logic [FRAME_BITS-1:0] fullVec;
  logic              unusedWr;

  assign unusedWr = ^{regWrData[31:30], regWrData[28], regAddr[1:0]};

  assign newCmd   = mdioCmd_t'(regWrData[27:0]);
  assign wrCmd    = regWrEn && (regAddr[ADDR_W-1:2] == CMD_WORD) && !busyQ;
  assign wrCfg    = regWrEn && (regAddr[ADDR_W-1:2] == CFG_WORD) && !busyQ;
  assign opValid  = (newCmd.op == OP_WRITE) || (newCmd.op == OP_READ);
  assign startReq = wrCmd && regWrData[29] && opValid && c22Q;
  assign isRead   = (cmdQ.op == OP_READ);
  assign nextIdx  = bitIdx + 1'b1;

  // frame image built from the word being written; read frames release TA
  assign taPat    = (newCmd.op == OP_READ) ? 2'b11 : 2'b10;
  assign fullVec  = {{PRE_BITS{1'b1}}, 2'b01, newCmd.op, newCmd.phy,
                     newCmd.regAddr, taPat, newCmd.data};
  assign frameVec = preOffQ ? (fullVec << PRE_BITS) : fullVec;

  always_comb begin
    strobe         = '0;
    strobe.load    = startReq;
    strobe.advance = busyQ && fallTick && (bitIdx != IDX_W'(IDX_LAST));
    strobe.finish  = busyQ && fallTick && (bitIdx == IDX_W'(IDX_LAST));
    strobe.drive   = !(isRead && (nextIdx >= IDX_W'(IDX_TA1)));
    strobe.capTa   = busyQ && riseTick && isRead && (bitIdx == IDX_W'(IDX_TA2));
    strobe.capData = busyQ && riseTick && isRead && (bitIdx >= IDX_W'(IDX_DATA0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= '0;
      busyQ   <= 1'b0;
      failQ   <= 1'b0;
      c22Q    <= 1'b1;
      preOffQ <= 1'b0;
      divQ    <= DIV_RESET;
      bitIdx  <= '0;
    end else begin
      if (wrCmd) cmdQ <= newCmd;
      if (wrCfg) begin
        c22Q    <= regWrData[0];
        divQ    <= regWrData[4 +: DIV_W];
        preOffQ <= regWrData[12];
      end
      if (startReq) begin
        busyQ  <= 1'b1;
        failQ  <= 1'b0;
        bitIdx <= preOffQ ? IDX_W'(PRE_BITS) : '0;
      end
      if (strobe.advance) bitIdx <= nextIdx;
      if (strobe.finish) begin
        busyQ <= 1'b0;
        if (isRead) begin
          cmdQ.data <= rdData;
          failQ     <= taBit;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr[ADDR_W-1:2] == CMD_WORD) begin
      regRdData = {2'b00, busyQ, failQ, cmdQ};
    end else if (regAddr[ADDR_W-1:2] == CFG_WORD) begin
      regRdData[0]          = c22Q;
      regRdData[4 +: DIV_W] = divQ;
      regRdData[12]         = preOffQ;
    end
  end

  assign run       = busyQ;
  assign busy      = busyQ;
  assign divVal    = divQ;
  assign cmdFields = cmdQ;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DIV_W      = 6,
  parameter int REF_HZ     = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int DIV_MAX   = (1 << DIV_W) - 1;
  localparam int DIV_CALC  = (REF_HZ + 2*MDC_MAX_HZ - 1) / (2*MDC_MAX_HZ) - 1;
  localparam int DIV_CLAMP = (DIV_CALC > DIV_MAX) ? DIV_MAX : ((DIV_CALC < 0) ? 0 : DIV_CALC);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(DIV_CLAMP);

  mdioStrobe_t           strobeW;
  logic                  runW, riseW, fallW, taW, busyW;
  logic [15:0]           rdW;
  logic [DIV_W-1:0]      divW;
  logic [FRAME_BITS-1:0] frameW;
  mdioCmd_t              fieldsW;

  mdio_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .riseTick(riseW),
    .fallTick(fallW), .taBit(taW), .rdData(rdW), .run(runW), .strobe(strobeW),
    .divVal(divW), .frameVec(frameW), .busy(busyW), .cmdFields(fieldsW)
  );

  mdio_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .run(runW), .strobe(strobeW), .divVal(divW),
    .frameVec(frameW), .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .riseTick(riseW), .fallTick(fallW), .taBit(taW),
    .rdData(rdW)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busy,
  input logic [27:0] fields
);
  // R9: lines quiet outside a frame
  a_r9_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  // R9: data output only moves together with a falling MDC edge
  a_r9_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> $fell(mdc));

  // R3: a launched frame begins driving with MDC still low
  a_r3_start_drives: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (mdioOe && !mdc));

  // R10: command fields frozen while a frame is in flight
  a_r10_fields_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(fields));
endmodule

bind mdio_master mdio_master_chk chk_i (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busyW), .fields(fieldsW)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CMD = 4'h0;
  localparam logic [3:0] A_CFG = 4'h4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int errors = 0;
  int riseCnt = 0;
  time t0 = 0, t1 = 0;
  logic recOut [64];
  logic recOe  [64];
  logic [15:0] respData = '0;
  logic respTa = 1'b0;
  int respBits = 64;

  // PHY-side recorder and responder
  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      recOut[riseCnt] = mdioOut;
      recOe[riseCnt]  = mdioOe;
    end
    if (riseCnt == 0) t0 = $time;
    if (riseCnt == 1) t1 = $time;
    riseCnt++;
  end

  always @(negedge mdc) begin
    int k;
    k = riseCnt;
    if (k == respBits - 17) mdioIn = respTa;
    else if (k >= respBits - 16 && k < respBits) mdioIn = respData[respBits-1-k];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin
      regRead(A_CMD, v);
      n++;
    end while (v[29] && n < 20000);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] cmdVal(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] rga, input logic [15:0] d);
    return {4'b0000, op, phy, rga, d};
  endfunction

  task automatic launch(input logic [31:0] v);
    logic [31:0] rb;
    riseCnt = 0;
    regWrite(A_CMD, v | 32'h2000_0000);
    regRead(A_CMD, rb);
    check(rb[29] == 1'b1, "R3 busy after launch", rb, v | 32'h2000_0000);
  endtask

  task automatic checkFrame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rga,
                            input logic [15:0] d, input bit preOff, input int div, input string req);
    logic [63:0] e;
    int n, off, bad;
    e = {32'hFFFF_FFFF, 2'b01, op, phy, rga, (op == 2'b10) ? 2'b00 : 2'b10, d};
    n = preOff ? 32 : 64;
    off = 64 - n;
    bad = 0;
    check(riseCnt == n, {req, " R4 MDC cycle count"}, riseCnt, n);
    for (int k = 0; k < n; k++) begin
      bit rel;
      rel = (op == 2'b10) && (k >= n - 18);
      if (recOe[k] !== !rel) bad++;
      else if (!rel && recOut[k] !== e[63-off-k]) bad++;
    end
    check(bad == 0, {req, " R4 bit stream"}, bad, 0);
    check(32'(t1 - t0) == 32'(2*(div+1)*CLK_PERIOD), "R8 MDC period", 32'(t1 - t0),
          32'(2*(div+1)*CLK_PERIOD));
    check(mdc == 1'b0 && mdioOe == 1'b0, "R9 idle after frame", {mdc, mdioOe}, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    regRead(A_CMD, v);
    check(v == 32'h0, "R1 command reset", v, 32'h0);
    regRead(A_CFG, v);
    check(v == 32'h91, "R1 config reset", v, 32'h91);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 lines at reset", {mdc, mdioOe}, 0);
  endtask

  task automatic t_default_div();
    launch(cmdVal(2'b01, 5'h01, 5'h02, 16'hA5A5));
    waitIdle();
    checkFrame(2'b01, 5'h01, 5'h02, 16'hA5A5, 1'b0, 9, "R5 default divider");
  endtask

  task automatic t_layout_rmw();
    logic [31:0] v, w;
    regWrite(A_CFG, 32'h0000_0001);
    w = cmdVal(2'b01, 5'h15, 5'h0A, 16'hBEEF);
    riseCnt = 0;
    regWrite(A_CMD, w);
    repeat (10) @(negedge clk);
    regRead(A_CMD, v);
    check(v == w, "R2 field readback", v, w);
    check(riseCnt == 0, "R11 no frame without start", riseCnt, 0);
    launch(v);
    waitIdle();
    checkFrame(2'b01, 5'h15, 5'h0A, 16'hBEEF, 1'b0, 0, "R11 R5 read-modify-write launch");
    regRead(A_CMD, v);
    check(v == w, "R5 write leaves fields", v, w);
  endtask

  task automatic t_read(input bit preOff, input int div, input logic ta, input logic [15:0] d);
    logic [31:0] v, exp;
    regWrite(A_CFG, (32'(preOff) << 12) | (32'(div) << 4) | 32'h1);
    respData = d; respTa = ta; respBits = preOff ? 32 : 64;
    launch(cmdVal(2'b10, 5'h1F, 5'h01, 16'h0000));
    waitIdle();
    checkFrame(2'b10, 5'h1F, 5'h01, 16'h0000, preOff, div, "R6 read frame");
    regRead(A_CMD, v);
    exp = cmdVal(2'b10, 5'h1F, 5'h01, d) | (ta ? 32'h1000_0000 : 32'h0);
    check(v == exp, ta ? "R7 read-fail flag" : "R6 read data returned", v, exp);
  endtask

  task automatic t_fail_clear();
    logic [31:0] v;
    regWrite(A_CFG, 32'h0000_0001);
    launch(cmdVal(2'b01, 5'h03, 5'h04, 16'h1234));
    waitIdle();
    regRead(A_CMD, v);
    check(v[28] == 1'b0, "R7 fail cleared by new frame", v, cmdVal(2'b01, 5'h03, 5'h04, 16'h1234));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v, w;
    regWrite(A_CFG, 32'h0000_0011);
    w = cmdVal(2'b01, 5'h06, 5'h07, 16'h0F0F);
    launch(w);
    regWrite(A_CMD, cmdVal(2'b10, 5'h11, 5'h12, 16'hFFFF) | 32'h2000_0000);
    regWrite(A_CFG, 32'h0000_1051);
    waitIdle();
    regRead(A_CMD, v);
    check(v == w, "R10 command write ignored while busy", v, w);
    regRead(A_CFG, v);
    check(v == 32'h11, "R10 config write ignored while busy", v, 32'h11);
    checkFrame(2'b01, 5'h06, 5'h07, 16'h0F0F, 1'b0, 1, "R10 frame unaffected");
  endtask

  task automatic t_bad_start();
    logic [31:0] v;
    regWrite(A_CFG, 32'h0000_0001);
    riseCnt = 0;
    regWrite(A_CMD, cmdVal(2'b00, 5'h02, 5'h02, 16'h0) | 32'h2000_0000);
    regRead(A_CMD, v);
    check(v[29] == 1'b0, "R3 opcode 00 not launched", v, 0);
    regWrite(A_CMD, cmdVal(2'b11, 5'h02, 5'h02, 16'h0) | 32'h2000_0000);
    regRead(A_CMD, v);
    check(v[29] == 1'b0, "R3 opcode 11 not launched", v, 0);
    regWrite(A_CFG, 32'h0000_0000);
    regWrite(A_CMD, cmdVal(2'b01, 5'h02, 5'h02, 16'h0) | 32'h2000_0000);
    regRead(A_CMD, v);
    check(v[29] == 1'b0, "R3 framing disabled not launched", v, 0);
    repeat (40) @(negedge clk);
    check(riseCnt == 0, "R3 no MDC edges on refused start", riseCnt, 0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R9 lines idle", {mdc, mdioOe}, 0);
    regWrite(A_CFG, 32'h0000_0001);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_default_div();
    t_layout_rmw();
    t_read(1'b0, 3, 1'b0, 16'h5A3C);
    t_read(1'b1, 1, 1'b1, 16'hC001);
    t_fail_clear();
    t_busy_ignore();
    t_bad_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule